// File: doc/BRIEF.md
# Character-Cell Raster Text Controller

This block turns a screen of character codes into a one-bit serial pixel stream with line and frame sync pulses for a character-oriented raster display. Four wrapping counters are chained so that each one advances when the one below it wraps. From the lowest to the highest they track the dot within a cell, the cell column, the pixel line inside the character, and the character row. The column and row counters form the address of a cell in an internal display RAM. The 7-bit code read from that address, together with the current pixel line, selects one 7-dot row from a built-in character generator.

At the last dot of every cell, the selected row is loaded in parallel into a shift register. The shift register then sends that row out one dot per clock, leftmost dot first. The code for a given column is read again on every pixel line of its character row, so the RAM holds only one code per cell. A processor fills the RAM through a simple write port. This port works at any time, including while the raster is held in reset.

Top module: `txt_display_ctrl`

## Requirements
- R1: A cell is 7 dots wide and the dot counter steps 0..6 once per clock, so exactly one video dot leaves per clock cycle. Consecutive line pulses are exactly 7×COLS cycles apart.
- R2: The column counter runs 0..COLS-1 and advances when the dot counter wraps. `hsync` is high for exactly one clock: the cycle in which the column counter wraps (dot 6 of the last column). Counting cycles from 0 after reset release, the first pulse is in cycle 7×COLS-1.
- R3: The pixel-line counter runs 0..LINES-1 and advances once per `hsync`. The same column of the same character row is read again on every pixel line.
- R4: The character-row counter runs 0..ROWS-1 and advances when the line counter wraps. `vsync` is high for one clock, in the last cycle of each frame (cycle index 7×COLS×LINES×ROWS-1 modulo the frame), always together with `hsync`. Each frame contains LINES×ROWS line pulses.
- R5: The display RAM address of the cell being fetched is row×COLS+column.
- R6: The dot row for a cell is loaded at that cell's last dot. Its bits come out in the following 7 cycles, bit 6 first and bit 0 last. During the first 7 cycles after reset, `video` is 0.
- R7: Code 0x20 (space) is blank on every line. Code 0x41 ('A') gives, on lines 0..6 with bit 6 as the leftmost dot: 0011100, 0100010, 0100010, 0111110, 0100010, 0100010, 0100010. Letters 0x41..0x5A draw only in bits 5..1.
- R8: Pixel lines 7 and up are blank for every code.
- R9: Every code other than 0x20 and 0x41..0x5A (for example 0x00, 0x61, 0x7F) is blank on every line.
- R10: When `cpu_we` is high at a rising edge, `cpu_data` is stored at `cpu_addr`. This also works during reset. The new code appears the next time that cell is fetched. Addresses at or beyond COLS×ROWS are ignored.
- R11: While `rst_n` is low, all counters are 0 and `video`, `hsync` and `vsync` are 0. The RAM contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset of the raster logic |
| cpu_we | input | 1 | Display RAM write enable |
| cpu_addr | input | AW = clog2(COLS×ROWS) | Display RAM write address, row×COLS+column |
| cpu_data | input | 7 | Character code to store |
| video | output | 1 | Serial pixel output, 1 = lit dot |
| hsync | output | 1 | One-clock line pulse at column overflow |
| vsync | output | 1 | One-clock frame pulse at row overflow |

## Verification
A wrong dot or column count shifts `hsync` away from its fixed cycle index within one line period. A wrong line or row counter moves `vsync` or changes the number of line pulses in the first frame. An address or fetch error shows up as a wrong glyph at `video` in the very cell it hits. That cell's dots appear in the seven cycles after its load, so the bench predicts every dot of two full frames and a live RAM rewrite cycle by cycle. A fault therefore surfaces no later than the next visit to the affected cell.

// File: rtl/txt_pkg.sv
package txt_pkg;

    localparam int CODE_W  = 7;
    localparam int GLYPH_W = 7;
    localparam int GLYPH_H = 7;
    localparam int LINE_SEL_W = 4;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [GLYPH_W-1:0] dot_row_t;

    // 5x7 letter bitmaps, top row in the most significant five bits.
    function automatic logic [34:0] letter_bitmap(input code_t code);
        logic [34:0] b;
        unique case (code)
            7'h41: b = 35'b01110_10001_10001_11111_10001_10001_10001;
            7'h42: b = 35'b11110_10001_10001_11110_10001_10001_11110;
            7'h43: b = 35'b01110_10001_10000_10000_10000_10001_01110;
            7'h44: b = 35'b11110_10001_10001_10001_10001_10001_11110;
            7'h45: b = 35'b11111_10000_10000_11110_10000_10000_11111;
            7'h46: b = 35'b11111_10000_10000_11110_10000_10000_10000;
            7'h47: b = 35'b01110_10001_10000_10111_10001_10001_01111;
            7'h48: b = 35'b10001_10001_10001_11111_10001_10001_10001;
            7'h49: b = 35'b01110_00100_00100_00100_00100_00100_01110;
            7'h4A: b = 35'b00111_00010_00010_00010_00010_10010_01100;
            7'h4B: b = 35'b10001_10010_10100_11000_10100_10010_10001;
            7'h4C: b = 35'b10000_10000_10000_10000_10000_10000_11111;
            7'h4D: b = 35'b10001_11011_10101_10101_10001_10001_10001;
            7'h4E: b = 35'b10001_10001_11001_10101_10011_10001_10001;
            7'h4F: b = 35'b01110_10001_10001_10001_10001_10001_01110;
            7'h50: b = 35'b11110_10001_10001_11110_10000_10000_10000;
            7'h51: b = 35'b01110_10001_10001_10001_10101_10010_01101;
            7'h52: b = 35'b11110_10001_10001_11110_10100_10010_10001;
            7'h53: b = 35'b01111_10000_10000_01110_00001_00001_11110;
            7'h54: b = 35'b11111_00100_00100_00100_00100_00100_00100;
            7'h55: b = 35'b10001_10001_10001_10001_10001_10001_01110;
            7'h56: b = 35'b10001_10001_10001_10001_10001_01010_00100;
            7'h57: b = 35'b10001_10001_10001_10101_10101_10101_01010;
            7'h58: b = 35'b10001_10001_01010_00100_01010_10001_10001;
            7'h59: b = 35'b10001_10001_01010_00100_00100_00100_00100;
            7'h5A: b = 35'b11111_00001_00010_00100_01000_10000_11111;
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/txt_wrap_counter.sv
module txt_wrap_counter #(
    parameter int LIMIT = 7,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         last,
    output logic         wrap
);

    assign last = (count == W'(LIMIT - 1));
    assign wrap = step & last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step) begin
            count <= last ? '0 : count + 1'b1;
        end
    end

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= LIMIT - 1);

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));

endmodule

// File: rtl/txt_display_ram.sv
module txt_display_ram import txt_pkg::*; #(
    parameter int DEPTH = 5120,
    parameter int AW    = 13
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  code_t         wdata,
    input  logic [AW-1:0] raddr,
    output code_t         rdata
);

    code_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && int'(waddr) < DEPTH) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH) begin
            rdata = mem[raddr];
        end
    end

endmodule

// File: rtl/txt_char_rom.sv
module txt_char_rom import txt_pkg::*; (
    input  code_t                 code,
    input  logic [LINE_SEL_W-1:0] line,
    output dot_row_t              pattern
);

    logic [34:0] bitmap;
    logic [4:0]  slice;

    always_comb begin
        bitmap  = letter_bitmap(code);
        slice   = '0;
        pattern = '0;
        if (int'(line) < GLYPH_H) begin
            slice   = bitmap[34 - 5 * int'(line) -: 5];
            pattern = {1'b0, slice, 1'b0};
        end
    end

endmodule

// File: rtl/txt_pixel_shifter.sv
module txt_pixel_shifter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] pattern,
    output logic         video
);

    logic [W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= pattern;
        end else begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign video = sreg[W-1];

    assert_first_dot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (video == $past(pattern[W-1])));

    assert_second_dot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ##1 (video == $past(pattern[W-2], 2)));

endmodule

// File: rtl/txt_display_ctrl.sv
module txt_display_ctrl import txt_pkg::*; #(
    parameter int COLS  = 80,
    parameter int LINES = 9,
    parameter int ROWS  = 64,
    localparam int CELLS = COLS * ROWS,
    localparam int AW    = $clog2(CELLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [6:0]    cpu_data,
    output logic          video,
    output logic          hsync,
    output logic          vsync
);

    localparam int DW = (GLYPH_W > 1) ? $clog2(GLYPH_W) : 1;
    localparam int CW = (COLS    > 1) ? $clog2(COLS)    : 1;
    localparam int LW = (LINES   > 1) ? $clog2(LINES)   : 1;
    localparam int RW = (ROWS    > 1) ? $clog2(ROWS)    : 1;

    logic [DW-1:0] dot_cnt;
    logic [CW-1:0] col_cnt;
    logic [LW-1:0] line_cnt;
    logic [RW-1:0] row_cnt;
    logic dot_last, col_last, line_last, row_last;
    logic dot_wrap, col_wrap, line_wrap, row_wrap;

    txt_wrap_counter #(.LIMIT(GLYPH_W)) u_dot (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .count(dot_cnt), .last(dot_last), .wrap(dot_wrap));

    txt_wrap_counter #(.LIMIT(COLS)) u_col (
        .clk(clk), .rst_n(rst_n), .step(dot_wrap),
        .count(col_cnt), .last(col_last), .wrap(col_wrap));

    txt_wrap_counter #(.LIMIT(LINES)) u_line (
        .clk(clk), .rst_n(rst_n), .step(col_wrap),
        .count(line_cnt), .last(line_last), .wrap(line_wrap));

    txt_wrap_counter #(.LIMIT(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .step(line_wrap),
        .count(row_cnt), .last(row_last), .wrap(row_wrap));

    logic [AW-1:0]         fetch_addr;
    code_t                 fetch_code;
    logic [LINE_SEL_W-1:0] rom_line;
    dot_row_t              rom_row;

    assign fetch_addr = AW'(row_cnt) * AW'(COLS) + AW'(col_cnt);
    assign rom_line   = LINE_SEL_W'(line_cnt);

    txt_display_ram #(.DEPTH(CELLS), .AW(AW)) u_ram (
        .clk(clk), .we(cpu_we), .waddr(cpu_addr), .wdata(cpu_data),
        .raddr(fetch_addr), .rdata(fetch_code));

    txt_char_rom u_rom (
        .code(fetch_code), .line(rom_line), .pattern(rom_row));

    txt_pixel_shifter #(.W(GLYPH_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(dot_wrap),
        .pattern(rom_row), .video(video));

    assign hsync = col_wrap;
    assign vsync = row_wrap;

    assert_hsync_home_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (col_cnt == '0 && dot_cnt == '0));

    assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && !line_last) |=> (line_cnt == $past(line_cnt) + 1'b1));

    assert_vsync_with_hsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> hsync);

    assert_vsync_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (row_cnt == '0 && line_cnt == '0 && col_cnt == '0));

    assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fetch_addr) < CELLS);

    assert_blank_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_wrap && int'(line_cnt) >= GLYPH_H) |=> !video);

endmodule

// File: tb/txt_display_ctrl_tb.sv
module txt_display_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int C  = 4;
    localparam int L  = 9;
    localparam int RR = 3;
    localparam int NC = C * RR;
    localparam int AW = $clog2(NC);
    localparam int LINE_T  = 7 * C;
    localparam int FRAME_T = 7 * C * L * RR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [6:0] cpu_data = '0;
    logic video, hsync, vsync;

    txt_display_ctrl #(.COLS(C), .LINES(L), .ROWS(RR)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .video(video), .hsync(hsync), .vsync(vsync));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    string scen = "R5";
    logic [6:0] model_mem [NC];
    logic [6:0] shown = '0;
    logic [6:0] next_pat = '0;
    string shown_tag = "R6";
    string next_tag = "R6";

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // R7 glyph rows for 'A'; all other codes used here are blank (R7 R9)
    function automatic logic [6:0] exp_row(input logic [6:0] code, input int ln);
        if (code != 7'h41 || ln >= 7) return 7'b0;
        case (ln)
            0: return 7'b0011100;
            3: return 7'b0111110;
            default: return 7'b0100010;
        endcase
    endfunction

    function automatic string cause_tag(input logic [6:0] code, input int ln);
        if (ln >= 7) return "R8";
        if (code == 7'h41 || code == 7'h20) return "R7";
        return "R9";
    endfunction

    // Cycle-accurate monitor: model of R1..R9 driven from the bench cycle index
    always @(negedge clk) begin
        if (mon_on) begin
            int t, d, k;
            t = cyc; d = t % 7; k = t / 7;
            if (d == 0 && t > 0) begin
                shown = next_pat;
                shown_tag = next_tag;
            end
            check($sformatf("%s R3 R6 %s video", scen, shown_tag), int'(video),
                  (t < 7) ? 0 : int'(shown[6 - d]));
            check($sformatf("%s R2 hsync", scen), int'(hsync),
                  int'((t % LINE_T) == LINE_T - 1));
            check($sformatf("%s R4 vsync", scen), int'(vsync),
                  int'((t % FRAME_T) == FRAME_T - 1));
            if (d == 6) begin
                int col, ln, rw;
                col = k % C; ln = (k / C) % L; rw = (k / (C * L)) % RR;
                next_pat = exp_row(model_mem[rw * C + col], ln);
                next_tag = cause_tag(model_mem[rw * C + col], ln);
            end
        end
    end

    task automatic ram_write(input int a, input logic [6:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = AW'(a); cpu_data = d;
        @(posedge clk);
        if (a < NC) model_mem[a] = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1 mon_on = 1'b1;
    endtask

    // R11 R10: outputs quiet in reset; RAM loaded while reset is held
    task automatic t_reset_state();
        logic [6:0] init [NC] = '{7'h41, 7'h20, 7'h61, 7'h41,
                                  7'h7F, 7'h41, 7'h20, 7'h00,
                                  7'h20, 7'h20, 7'h41, 7'h41};
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        for (int i = 0; i < NC; i++) ram_write(i, init[i]);
        @(negedge clk);
        check("R11 video in reset", int'(video), 0);
        check("R11 hsync in reset", int'(hsync), 0);
        check("R11 vsync in reset", int'(vsync), 0);
    endtask

    // R5 R7 R8 R9: two full frames checked dot by dot by the monitor
    task automatic t_frame_scan();
        int f0;
        scen = "R5";
        f0 = fails;
        release_reset();
        repeat (2 * FRAME_T) @(negedge clk);
        check("R5 frame scan clean", fails - f0, 0);
    endtask

    // R1 R2 R3 R4: pulse spacing and counts over one frame
    task automatic t_sync_period();
        int h_cnt, v_cnt, last_h, gap_bad, hv_bad;
        h_cnt = 0; v_cnt = 0; last_h = -1; gap_bad = 0; hv_bad = 0;
        while ((cyc % FRAME_T) != 0) @(negedge clk);
        repeat (FRAME_T) begin
            if (hsync) begin
                if (last_h >= 0 && cyc - last_h != LINE_T) gap_bad++;
                last_h = cyc;
                h_cnt++;
            end
            if (vsync) begin
                v_cnt++;
                if (!hsync) hv_bad++;
            end
            @(negedge clk);
        end
        check("R1 line pulse spacing errors", gap_bad, 0);
        check("R3 line pulses per frame", h_cnt, L * RR);
        check("R4 frame pulses per frame", v_cnt, 1);
        check("R4 vsync without hsync", hv_bad, 0);
    endtask

    // R10: live rewrite of row 0 while row 2 is scanned; out-of-range write ignored
    task automatic t_live_write();
        int f0;
        scen = "R10";
        f0 = fails;
        while ((cyc % FRAME_T) < 2 * C * L * 7 + 3) @(negedge clk);
        ram_write(1, 7'h41);
        ram_write(2, 7'h41);
        ram_write(NC + 1, 7'h41);
        ram_write(7, 7'h41);
        repeat (2 * FRAME_T) @(negedge clk);
        check("R10 live write scan clean", fails - f0, 0);
    endtask

    // R11: mid-frame reset clears outputs and restarts scan, RAM kept
    task automatic t_mid_reset();
        int f0;
        repeat (100) @(negedge clk);
        mon_on = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R11 video after async reset", int'(video), 0);
        check("R11 hsync after async reset", int'(hsync), 0);
        check("R11 vsync after async reset", int'(vsync), 0);
        repeat (4) @(negedge clk);
        scen = "R11";
        f0 = fails;
        release_reset();
        repeat (FRAME_T + 10) @(negedge clk);
        check("R11 restart scan clean", fails - f0, 0);
        mon_on = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        t_reset_state();
        t_frame_scan();
        t_sync_period();
        t_live_write();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule